// File: doc/BRIEF.md
# Polled Debug Serial Port

This block is a minimal serial console peripheral for a 32-bit memory-mapped bus. Software sees a single data word. Writing that word sends the low byte out on a serial line. Reading it returns the last byte that arrived on the receive line. The frame format is fixed: one low start bit, eight data bits with the least significant bit first, no parity, and one high stop bit. The line idles high. A clock-divider parameter sets the bit time.

The block has no status word. If software writes while a byte is still on the line, the port holds back the bus acknowledge, so the master waits until the transmitter is free. The write is then taken in. On the receive side there is no buffering beyond a single byte and a fresh flag. A read with no fresh byte returns all ones. A byte that is not read in time is overwritten by the next one.

The receiver sees a falling edge on the synchronised line and checks it again half a bit later. It then samples each data bit and the stop bit at its centre. Frames with a low stop bit are dropped. Accesses to any other address are left unacknowledged so that other targets can answer them.

Top module: `dbg_uart_port`

## Requirements
- R1: After reset the transmit line is high, the acknowledge is low, and the first read of the data word returns 32'hFFFF_FFFF.
- R2: A write to address BASE_ADDR (default 32'h1000_0000, offset 0) sends bits [7:0] of the write data as one frame on the transmit line: start bit low, data bits 0 to 7 in that order, stop bit high. Each bit lasts CLKS_PER_BIT clocks.
- R3: A write that arrives while a frame is being sent gets no acknowledge until the line has returned to idle. It is then accepted, and its byte follows the earlier frame without loss.
- R4: A read of the data word is acknowledged in the clock after the request is seen, with the idle transmitter and no contention. It returns the last received byte in bits [7:0] with bits [31:8] zero.
- R5: A read returns 32'hFFFF_FFFF when no byte has arrived since the previous read. Each read clears the fresh flag.
- R6: If a second byte arrives before the first is read, the next read returns only the second byte.
- R7: A frame whose stop bit is sampled low is dropped: the next read returns 32'hFFFF_FFFF, and a later good frame is still received.
- R8: A low pulse on the receive line shorter than half a bit time does not start a frame, and nothing is reported by the next read.
- R9: A request to any address other than BASE_ADDR is never acknowledged, and a write there sends nothing.
- R10: The acknowledge is a single-cycle pulse that is only given for a request present in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held by the master until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data; bits [7:0] are transmitted |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high for a read |
| bus_ack | output | 1 | One-cycle acknowledge |
| ser_txd | output | 1 | Serial transmit line, idles high |
| ser_rxd | input | 1 | Serial receive line |

## Verification
Assertions check these rules on every cycle:
- the acknowledge is a one-cycle pulse that answers an earlier request;
- no write is acknowledged, and no frame is started, while the transmitter is busy;
- the idle transmit line stays high;
- read data is either all ones or a zero-extended byte;
- a reported byte always had a high stop bit.

Only the bench scenarios can show the rest:
- the bit order and bit timing of frames on the line;
- that a stalled write is carried out after the earlier frame;
- overwrite of an unread byte;
- rejection of a short glitch or a bad stop bit, seen through later read values.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_START = 2'd1,
      TX_DATA  = 2'd2,
      TX_STOP  = 2'd3
   } tx_state_e;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_STOP  = 3'd3,
      RX_HOLD  = 3'd4
   } rx_state_e;

   // sentinel returned when no fresh byte is held
   function automatic logic [31:0] empty_word();
      return 32'hFFFF_FFFF;
   endfunction

endpackage

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
   import dbg_uart_pkg::*;
#(
   parameter int CLKS_PER_BIT = 16,
   parameter int BYTE_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] data,
   output logic              busy,
   output logic              txd
);
   localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
   localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(CLKS_PER_BIT - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

   initial begin
      if (CLKS_PER_BIT < 4) $error("CLKS_PER_BIT must be at least 4");
      if (BYTE_W < 2) $error("BYTE_W must be at least 2");
   end

   tx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bitn;
   logic [BYTE_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         shreg <= '0;
         txd   <= 1'b1;
      end else begin
         unique case (state)
            TX_IDLE: begin
               txd <= 1'b1;
               if (start) begin
                  shreg <= data;
                  txd   <= 1'b0;
                  cnt   <= LAST_CNT;
                  state <= TX_START;
               end
            end
            TX_START: begin
               if (cnt == '0) begin
                  txd   <= shreg[0];
                  shreg <= {1'b0, shreg[BYTE_W-1:1]};
                  bitn  <= '0;
                  cnt   <= LAST_CNT;
                  state <= TX_DATA;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            TX_DATA: begin
               if (cnt == '0) begin
                  cnt <= LAST_CNT;
                  if (bitn == LAST_BIT) begin
                     txd   <= 1'b1;
                     state <= TX_STOP;
                  end else begin
                     txd   <= shreg[0];
                     shreg <= {1'b0, shreg[BYTE_W-1:1]};
                     bitn  <= bitn + 1'b1;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            TX_STOP: begin
               if (cnt == '0) state <= TX_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign busy = (state != TX_IDLE);

   // R2
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_IDLE) |-> txd);

   // R3
   no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
   import dbg_uart_pkg::*;
#(
   parameter int CLKS_PER_BIT = 16,
   parameter int BYTE_W       = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   output logic              done,
   output logic [BYTE_W-1:0] data
);
   localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
   localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(CLKS_PER_BIT - 1);
   localparam logic [CW-1:0] HALF_CNT = CW'(CLKS_PER_BIT / 2 - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

   initial begin
      if (CLKS_PER_BIT < 4) $error("CLKS_PER_BIT must be at least 4");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) $error("SYNC_STAGES out of range 0..4");
   end

   logic rxs;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxs = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] pipe;
         always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[SYNC_STAGES-2+1-1:0], rxd} >> 0;
         end
         assign rxs = pipe[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bitn;
   logic [BYTE_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         shreg <= '0;
         done  <= 1'b0;
         data  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            RX_IDLE: begin
               if (!rxs) begin
                  cnt   <= HALF_CNT;
                  state <= RX_START;
               end
            end
            RX_START: begin
               if (cnt == '0) begin
                  if (!rxs) begin
                     cnt   <= LAST_CNT;
                     bitn  <= '0;
                     state <= RX_DATA;
                  end else begin
                     state <= RX_IDLE;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            RX_DATA: begin
               if (cnt == '0) begin
                  shreg <= {rxs, shreg[BYTE_W-1:1]};
                  cnt   <= LAST_CNT;
                  if (bitn == LAST_BIT) state <= RX_STOP;
                  else                  bitn  <= bitn + 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            RX_STOP: begin
               if (cnt == '0) begin
                  if (rxs) begin
                     done  <= 1'b1;
                     data  <= shreg;
                     state <= RX_IDLE;
                  end else begin
                     state <= RX_HOLD;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            RX_HOLD: begin
               if (rxs) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R7
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rxs));

endmodule

// File: rtl/dbg_uart_busif.sv
module dbg_uart_busif
   import dbg_uart_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          DATA_W    = 32,
   parameter int          BYTE_W    = 8,
   parameter logic [31:0] BASE_ADDR = 32'h1000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ack,
   input  logic              tx_busy,
   output logic              tx_start,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              rx_done,
   input  logic [BYTE_W-1:0] rx_data
);
   localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(BASE_ADDR);

   initial begin
      if (DATA_W < BYTE_W) $error("DATA_W must hold a byte");
      if (BASE_ADDR[1:0] != 2'b00) $error("BASE_ADDR must be word aligned");
   end

   logic              hit;
   logic              rd_take;
   logic              wr_take;
   logic              fresh;
   logic [BYTE_W-1:0] held;

   assign hit      = req && (addr == REG_ADDR) && !ack;
   assign rd_take  = hit && !we;
   assign wr_take  = hit && we && !tx_busy;
   assign tx_start = wr_take;
   assign tx_data  = wdata[BYTE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack   <= 1'b0;
         rdata <= '0;
         fresh <= 1'b0;
         held  <= '0;
      end else begin
         ack <= rd_take || wr_take;
         if (rd_take) begin
            rdata <= fresh ? DATA_W'(held) : DATA_W'(empty_word());
         end
         if (rx_done) begin
            held  <= rx_data;
            fresh <= 1'b1;
         end else if (rd_take) begin
            fresh <= 1'b0;
         end
      end
   end

   // R10
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R10
   ack_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(req));

   // R3
   stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && tx_busy) |=> !ack);

   // R9
   other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != REG_ADDR) |=> !ack);

   // R4
   rdata_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(!we) && rdata != DATA_W'(empty_word()))
         |-> (rdata[DATA_W-1:BYTE_W] == '0));

endmodule

// File: rtl/dbg_uart_port.sv
module dbg_uart_port
   import dbg_uart_pkg::*;
#(
   parameter int          CLKS_PER_BIT = 16,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [31:0] BASE_ADDR    = 32'h1000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_req,
   input  logic        bus_we,
   input  logic [31:0] bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        bus_ack,
   output logic        ser_txd,
   input  logic        ser_rxd
);
   localparam int BYTE_W = 8;

   logic              tx_busy;
   logic              tx_start;
   logic [BYTE_W-1:0] tx_data;
   logic              rx_done;
   logic [BYTE_W-1:0] rx_data;

   dbg_uart_busif #(
      .ADDR_W(32), .DATA_W(32), .BYTE_W(BYTE_W), .BASE_ADDR(BASE_ADDR)
   ) u_busif (
      .clk(clk), .rst_n(rst_n),
      .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .ack(bus_ack),
      .tx_busy(tx_busy), .tx_start(tx_start), .tx_data(tx_data),
      .rx_done(rx_done), .rx_data(rx_data)
   );

   dbg_uart_tx #(
      .CLKS_PER_BIT(CLKS_PER_BIT), .BYTE_W(BYTE_W)
   ) u_tx (
      .clk(clk), .rst_n(rst_n),
      .start(tx_start), .data(tx_data), .busy(tx_busy), .txd(ser_txd)
   );

   dbg_uart_rx #(
      .CLKS_PER_BIT(CLKS_PER_BIT), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_rx (
      .clk(clk), .rst_n(rst_n),
      .rxd(ser_rxd), .done(rx_done), .data(rx_data)
   );

endmodule

// File: tb/sim_dbg_uart_port.sv
module sim_dbg_uart_port;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 16;
   localparam logic [31:0] BASE = 32'h1000_0000;
   localparam logic [31:0] EMPTY = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ack;
   logic        ser_txd;
   logic        ser_rxd = 1'b1;

   int checks = 0;
   int errors = 0;
   logic [7:0] cap [0:15];
   int cap_n = 0;
   int cap_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_uart_port #(.CLKS_PER_BIT(NB), .SYNC_STAGES(2), .BASE_ADDR(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .ser_txd(ser_txd), .ser_rxd(ser_rxd)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // line monitor: decodes frames from the transmit line at bit centres
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ser_txd === 1'b0) begin
            logic [7:0] b;
            repeat (NB/2 - 1) @(negedge clk);
            if (ser_txd !== 1'b0) cap_bad++;
            for (int i = 0; i < 8; i++) begin
               repeat (NB) @(negedge clk);
               b[i] = ser_txd;
            end
            repeat (NB) @(negedge clk);
            if (ser_txd !== 1'b1) cap_bad++;
            if (cap_n < 16) cap[cap_n] = b;
            cap_n++;
         end
      end
   end

   task automatic bus_access(input logic w, input logic [31:0] a, input logic [31:0] d,
                             output logic [31:0] rd, output int cyc);
      @(negedge clk);
      bus_req = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!bus_ack && cyc < 40*NB);
      rd = bus_rdata;
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop_bit);
      @(negedge clk);
      ser_rxd = 1'b0;
      repeat (NB) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_rxd = b[i];
         repeat (NB) @(negedge clk);
      end
      ser_rxd = stop_bit;
      repeat (NB) @(negedge clk);
      ser_rxd = 1'b1;
      repeat (2*NB) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] rd; int cyc;
      check("R1 txd idle", {31'b0, ser_txd}, 32'd1);
      check("R1 ack low", {31'b0, bus_ack}, 32'd0);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R1 first read empty", rd, EMPTY);
   endtask

   task automatic t_send_one();
      logic [31:0] rd; int cyc; int n0;
      n0 = cap_n;
      bus_access(1'b1, BASE, 32'hABCD_EF5A, rd, cyc);
      check("R2 write ack latency", cyc, 1);
      repeat (12*NB) @(negedge clk);
      check("R2 one frame", cap_n - n0, 1);
      check("R2 low byte bits", {24'b0, cap[n0]}, 32'h5A);
      check("R2 framing", cap_bad, 0);
   endtask

   task automatic t_stall();
      logic [31:0] rd; int cyc; int n0;
      n0 = cap_n;
      bus_access(1'b1, BASE, 32'h0000_00C3, rd, cyc);
      bus_access(1'b1, BASE, 32'h0000_0017, rd, cyc);
      check("R3 stall length", {31'b0, cyc > 9*NB}, 32'd1);
      check("R3 stall bounded", {31'b0, cyc <= 10*NB + 2}, 32'd1);
      repeat (12*NB) @(negedge clk);
      check("R3 two frames", cap_n - n0, 2);
      check("R3 first byte", {24'b0, cap[n0]}, 32'hC3);
      check("R3 second byte", {24'b0, cap[n0+1]}, 32'h17);
   endtask

   task automatic t_receive();
      logic [31:0] rd; int cyc;
      send_frame(8'h96, 1'b1);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R4 read ack latency", cyc, 1);
      check("R4 received byte", rd, 32'h0000_0096);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R5 cleared after read", rd, EMPTY);
      send_frame(8'h00, 1'b1);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R4 zero byte", rd, 32'h0000_0000);
   endtask

   task automatic t_overrun();
      logic [31:0] rd; int cyc;
      send_frame(8'h11, 1'b1);
      send_frame(8'hE2, 1'b1);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R6 newer byte wins", rd, 32'h0000_00E2);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R6 older byte gone", rd, EMPTY);
   endtask

   task automatic t_bad_stop();
      logic [31:0] rd; int cyc;
      send_frame(8'h3C, 1'b0);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R7 bad stop dropped", rd, EMPTY);
      send_frame(8'h81, 1'b1);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R7 recovery frame", rd, 32'h0000_0081);
   endtask

   task automatic t_glitch();
      logic [31:0] rd; int cyc;
      @(negedge clk);
      ser_rxd = 1'b0;
      repeat (NB/2 - 4) @(negedge clk);
      ser_rxd = 1'b1;
      repeat (12*NB) @(negedge clk);
      bus_access(1'b0, BASE, '0, rd, cyc);
      check("R8 glitch ignored", rd, EMPTY);
   endtask

   task automatic t_other_addr();
      int acks = 0; int n0;
      n0 = cap_n;
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = BASE + 32'd4; bus_wdata = 32'h55;
      repeat (30) begin
         @(negedge clk);
         if (bus_ack) acks++;
      end
      bus_we = 1'b0; bus_addr = 32'h2000_0000;
      repeat (30) begin
         @(negedge clk);
         if (bus_ack) acks++;
      end
      bus_req = 1'b0;
      repeat (12*NB) @(negedge clk);
      check("R9 no ack elsewhere", acks, 0);
      check("R9 nothing sent", cap_n - n0, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_send_one();
      t_stall();
      t_receive();
      t_overrun();
      t_bad_stop();
      t_glitch();
      t_other_addr();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule